// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate

This block multiplies two signed 8-bit operands and adds each product into a running signed 32-bit total. It uses two register stages. The first stage holds the product, a flag that marks the product as valid, and a pending request to clear. The second stage holds the total. A caller presents an operand pair with `mac_en` high, and that product enters the total at the next clock edge. A new pair can be accepted on every cycle.

A clear request passes through the first stage alongside the product. As a result, the total drops to zero one edge after the request is registered. A product that was already registered before the clear still lands in the total. A product that is registered together with the clear is thrown away. Reset is asynchronous and active-low. It empties both stages, so any product in flight is lost.

Top module: `mac_pipe`

## Requirements
- R1: The operands are two's-complement 8-bit values. Each product is sign-extended to 32 bits before it is added. For example, -5×3 adds -15, -128×-128 adds +16384, and 127×127 adds +16129.
- R2: A pair sampled with `mac_en` high at clock edge k changes `acc_out` at edge k+1, and not before.
- R3: When `mac_en` is low at an edge, the operands at that edge add nothing to `acc_out`, whatever their values.
- R4: Pairs on consecutive cycles are each added once, one per cycle. The products 6, 20 and 42 give 6, 26 and then 68.
- R5: When `clr_req` is high at edge k, `acc_out` is 0 after edge k+1. A product captured at edge k-1 is still added at edge k.
- R6: When a valid product and a clear are registered at the same edge, the clear wins. `acc_out` becomes 0 and that product is lost.
- R7: While `rst_n` is low, `acc_out` is 0 and nothing is pending. A product captured just before reset does not appear after reset is released.
- R8: The total wraps modulo 2^32 and never saturates. Adding 16384 a total of 131072 times from zero gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mac_en | input | 1 | Accept the operand pair at this edge |
| clr_req | input | 1 | Request to zero the total, one stage later |
| opa | input | 8 | Signed operand A |
| opb | input | 8 | Signed operand B |
| acc_out | output | 32 | Signed running total |

## Verification
The vector table runs three kinds of stream:
- A back-to-back run of positive products shows that none is lost or counted twice.
- Operand pairs that mix signs, including both 8-bit extremes, expose any sign-extension fault.
- Cycles with `mac_en` low but nonzero operands on the inputs separate enable gating from simple input zeroing.

Clear requests are placed in two positions. One sits behind a product already registered, which must still be added. The other arrives together with a valid product, which must be dropped. Directed tests then cover a reset that cuts off an in-flight product, and a long run that carries the total past the signed 32-bit limit.

// File: rtl/mac_pkg.sv
package mac_pkg;
  parameter int unsigned OP_W  = 8;
  parameter int unsigned ACC_W = 32;
  localparam int unsigned PROD_W = 2 * OP_W;

  typedef logic signed [OP_W-1:0]   op_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  function automatic acc_t widen(prod_t p);
    return acc_t'(p);
  endfunction
endpackage

// File: rtl/mac_capture.sv
module mac_capture
  import mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  clr_i,
  input  op_t   a_i,
  input  op_t   b_i,
  output prod_t prod_o,
  output logic  vld_o,
  output logic  clr_o
);
  prod_t prod_q, prod_d;
  logic  vld_q, vld_d;
  logic  clr_q, clr_d;

  always_comb begin
    prod_d = prod_q;
    if (en_i) prod_d = a_i * b_i;
    vld_d = en_i;
    clr_d = clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      vld_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      prod_q <= prod_d;
      vld_q  <= vld_d;
      clr_q  <= clr_d;
    end
  end

  assign prod_o = prod_q;
  assign vld_o  = vld_q;
  assign clr_o  = clr_q;

  // R3: an idle edge leaves nothing valid and keeps the held product
  a_r3_gate_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !vld_o);
  a_r3_prod_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(prod_o));
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  prod_t prod_i,
  input  logic  vld_i,
  input  logic  clr_i,
  output acc_t  acc_o
);
  acc_t acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr_i)      acc_d = '0;
    else if (vld_i) acc_d = acc_q + widen(prod_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R5: a registered clear empties the total
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0));
  // R6: the clear beats a valid product in the same stage
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && vld_i) |=> (acc_o == '0));
  // R3: nothing valid means the total holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !vld_i) |=> $stable(acc_o));
  // R1/R8: a valid product adds its sign-extended value, wrapping
  a_r8_wrap_add: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !clr_i) |=> (acc_o == acc_t'($past(acc_o) + acc_t'($past(prod_i)))));
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mac_en,
  input  logic                    clr_req,
  input  logic signed [OP_W-1:0]  opa,
  input  logic signed [OP_W-1:0]  opb,
  output logic signed [ACC_W-1:0] acc_out
);
  prod_t s1_prod;
  logic  s1_vld;
  logic  s1_clr;

  mac_capture u_cap (
    .clk(clk), .rst_n(rst_n), .en_i(mac_en), .clr_i(clr_req),
    .a_i(opa), .b_i(opb),
    .prod_o(s1_prod), .vld_o(s1_vld), .clr_o(s1_clr)
  );

  mac_accum u_acc (
    .clk(clk), .rst_n(rst_n), .prod_i(s1_prod), .vld_i(s1_vld),
    .clr_i(s1_clr), .acc_o(acc_out)
  );

  // R5: a clear at the ports empties the total two edges later
  a_r5_port_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> ##1 (acc_out == '0));
endmodule

// File: tb/mac_pipe_tb_top.sv
`timescale 1ns/1ps
module mac_pipe_tb_top;
  logic clk, rst_n, mac_en, clr_req;
  logic signed [7:0]  opa, opb;
  logic signed [31:0] acc_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  mac_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .clr_req(clr_req),
    .opa(opa), .opb(opb), .acc_out(acc_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {en, clr, a, b, expected acc_out after this edge}
  localparam int NV = 13;
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'sd2,   8'sd3,   32'sd0},     // R2 nothing yet
    {1'b1, 1'b0, 8'sd4,   8'sd5,   32'sd6},     // R4
    {1'b1, 1'b0, 8'sd6,   8'sd7,   32'sd26},    // R4
    {1'b0, 1'b0, 8'sd9,   8'sd9,   32'sd68},    // R4 last lands
    {1'b0, 1'b0, 8'sd0,   8'sd0,   32'sd68},    // R3 9x9 ignored
    {1'b1, 1'b0, 8'hFB,   8'sd3,   32'sd68},    // R1 -5x3 captured
    {1'b1, 1'b0, 8'h80,   8'h80,   32'sd53},    // R1
    {1'b1, 1'b0, 8'sd127, 8'sd127, 32'sd16437}, // R1
    {1'b0, 1'b1, 8'sd1,   8'sd1,   32'sd32566}, // R5 in-flight added
    {1'b1, 1'b1, 8'sd10,  8'sd10,  32'sd0},     // R5 cleared
    {1'b0, 1'b0, 8'sd0,   8'sd0,   32'sd0},     // R6 clear beats 100
    {1'b1, 1'b0, 8'hF6,   8'sd10,  32'sd0},     // R1 -10x10
    {1'b0, 1'b0, 8'sd0,   8'sd0,   32'hFFFFFF9C} // R1 -100
  };

  task automatic check(input string tag, input logic signed [31:0] exp);
    checks++;
    if (acc_out !== exp) begin
      errors++;
      $display("FAIL %s acc_out=%0d expected=%0d", tag, acc_out, exp);
    end
  endtask

  task automatic drive(input logic e, input logic c, input logic [7:0] a, input logic [7:0] b);
    mac_en = e; clr_req = c; opa = a; opb = b;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    drive(0, 0, 0, 0);
    rst_n = 1'b0;
    #1;
    check("R7", 32'sd0);
    do_reset();
    check("R7", 32'sd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][49], VEC[i][48], VEC[i][47:40], VEC[i][39:32]);
      @(posedge clk); #1;
      check($sformatf("R2/R4 vec%0d", i), VEC[i][31:0]);
    end

    // R7: reset discards an in-flight product
    do_reset();
    drive(1, 0, 8'sd7, 8'sd7);
    @(posedge clk); #1;
    drive(0, 0, 0, 0);
    rst_n = 1'b0;
    #1;
    check("R7", 32'sd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R7", 32'sd0);

    // R2: pair shows exactly one edge after capture
    drive(1, 0, 8'sd1, 8'sd127);
    @(posedge clk); #1;
    drive(0, 0, 8'sd5, 8'sd5);
    check("R2", 32'sd0);
    @(posedge clk); #1;
    check("R2", 32'sd127);

    // R8: wrap past the signed limit
    drive(0, 1, 0, 0);
    @(posedge clk); #1;
    drive(1, 0, 8'h80, 8'h80);
    @(posedge clk); #1;
    repeat (131071) @(posedge clk);
    #1 drive(0, 0, 0, 0);
    @(posedge clk); #1;
    check("R8", 32'h80000000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog acc_out=%0d expected=finish", acc_out);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule